// File: doc/BRIEF.md
# Dual Receive Queue Manager for a Shared Message RAM

This block keeps the bookkeeping for two receive queues whose elements are stored in a word-addressed message RAM that other logic owns. Each queue has its own base address, capacity (1 to 64 elements), fill threshold and element size code. The element size code gives the number of RAM words one element takes. An upstream filter reports each accepted message with a single-cycle pulse and the number of the queue it chose. In the same cycle the block answers with the RAM word address where that element must be written, and says whether the queue had room.

On the read side the host selects a queue and sees its oldest-element index and the RAM address of that element. After reading the element, the host writes back the index it consumed, which frees the slot. Per queue, the block holds the write index, read index, occupancy, a full status and three sticky interrupt flags: threshold reached, queue full and message dropped. Each flag is cleared by writing 1.

Top module: `rxq_fifo_mgr`

## Requirements
- R1: The two queues are fully independent. A put, acknowledge or flag clear addressed to one queue never changes the indices, occupancy or flags of the other.
- R2: The 3-bit size code sets the RAM words per element: 0→4, 1→5, 2→6, 3→7, 4→8, 5→10, 6→14, 7→18. These correspond to 8, 12, 16, 20, 24, 32, 48 and 64 data bytes.
- R3: `wr_addr` equals (base + write index × element words) modulo 2^14 for the queue on `acc_sel`. `rd_addr` equals (base + read index × element words) modulo 2^14 for the queue on `rd_sel`. Both are combinational.
- R4: A put to a queue that is not full asserts `wr_ok` in that cycle. On the next edge the write index moves to index+1, wrapping to 0 when that value reaches or exceeds the capacity, and the occupancy grows by one.
- R5: `full` of a queue is high exactly when its occupancy equals its capacity. A put that brings the occupancy to the capacity sets the full flag, which is bit 1 of that queue's 3-bit flag group.
- R6: A put to a full queue is dropped. `wr_ok` is low, the write index and occupancy do not change, and the drop flag (bit 2 of the group) is set.
- R7: An acknowledge with index k to a non-empty queue sets the read index to k+1, wrapping to 0 when that value reaches or exceeds the capacity, and lowers the occupancy by one. An acknowledge to an empty queue changes nothing.
- R8: A put that is accepted and an acknowledge that is accepted on the same queue in the same cycle leave the occupancy unchanged and advance both indices.
- R9: A put that raises the occupancy to the programmed threshold sets the threshold flag (bit 0 of the group). A threshold of 0, or one above the capacity, never sets it.
- R10: Flags are sticky until a 1 is written to the matching bit of `irq_clr`. If a set condition and a clear happen in the same cycle, the flag ends up set.
- R11: During reset all indices, occupancies and flags are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_start | input | NUM_Q*ADDR_W | Per-queue RAM word base address, queue q in slice q |
| cfg_depth | input | NUM_Q*(IDX_W+1) | Per-queue capacity, 1 to 2^IDX_W |
| cfg_wmark | input | NUM_Q*(IDX_W+1) | Per-queue occupancy threshold |
| cfg_dsize | input | NUM_Q*3 | Per-queue element size code |
| acc_valid | input | 1 | Accepted-message pulse |
| acc_sel | input | SEL_W | Queue chosen for the accepted message |
| wr_ok | output | 1 | Message stored (queue had room) |
| wr_addr | output | ADDR_W | RAM word address for the new element |
| ack_valid | input | 1 | Host acknowledge strobe |
| ack_sel | input | SEL_W | Queue being acknowledged |
| ack_idx | input | IDX_W | Index the host consumed |
| rd_sel | input | SEL_W | Queue selected for host read view |
| rd_get_idx | output | IDX_W | Read index of the selected queue |
| rd_addr | output | ADDR_W | RAM word address of the oldest element |
| put_idx | output | NUM_Q*IDX_W | Per-queue write index |
| get_idx | output | NUM_Q*IDX_W | Per-queue read index |
| fill | output | NUM_Q*(IDX_W+1) | Per-queue occupancy |
| full | output | NUM_Q | Per-queue full status |
| irq_flags | output | NUM_Q*3 | Per-queue flags: bit0 threshold, bit1 full, bit2 dropped |
| irq_clr | input | NUM_Q*3 | Write-1-to-clear, same layout as irq_flags |

## Verification
The hardest state to reach is a 64-deep queue that is exactly full, with a put and an acknowledge landing in the same cycle on a wrapped index pair. Random traffic alone seldom fills a deep queue, because acknowledges keep draining it. The stimulus therefore alternates between phases where puts dominate and phases where acknowledges dominate, using capacities drawn from 1, 2, 3, 64 and random values. Directed sequences on a shallow queue add overflow, a set-versus-clear collision and an acknowledge to an empty queue.

// File: rtl/rxq_pkg.sv
package rxq_pkg;
   localparam int WORDS_W = 5;

   typedef logic [2:0] dsize_t;

   // bit0 threshold, bit1 full, bit2 dropped
   typedef struct packed {
      logic lost;
      logic full;
      logic wmark;
   } irq_t;

   function automatic logic [WORDS_W-1:0] elem_words(dsize_t code);
      logic [WORDS_W-1:0] w;
      case (code)
         3'd0:    w = 5'd4;
         3'd1:    w = 5'd5;
         3'd2:    w = 5'd6;
         3'd3:    w = 5'd7;
         3'd4:    w = 5'd8;
         3'd5:    w = 5'd10;
         3'd6:    w = 5'd14;
         default: w = 5'd18;
      endcase
      return w;
   endfunction
endpackage

// File: rtl/rxq_addr_gen.sv
module rxq_addr_gen
   import rxq_pkg::*;
#(
   parameter int ADDR_W    = 14,
   parameter int IDX_W     = 6,
   parameter bit MULT_IMPL = 1'b1
) (
   input  logic [ADDR_W-1:0] base,
   input  logic [IDX_W-1:0]  idx,
   input  dsize_t            dsize,
   output logic [ADDR_W-1:0] addr
);
   localparam int PROD_W = IDX_W + WORDS_W;

   logic [WORDS_W-1:0] words;
   logic [PROD_W-1:0]  prod;

   assign words = elem_words(dsize);

   generate
      if (MULT_IMPL) begin : g_mul
         assign prod = PROD_W'(idx) * PROD_W'(words);
      end else begin : g_shift_add
         always_comb begin
            prod = '0;
            for (int b = 0; b < IDX_W; b++) begin
               if (idx[b]) prod = prod + (PROD_W'(words) << b);
            end
         end
      end
   endgenerate

   assign addr = base + ADDR_W'(prod);
endmodule

// File: rtl/rxq_state.sv
module rxq_state
   import rxq_pkg::*;
#(
   parameter  int IDX_W = 6,
   localparam int CNT_W = IDX_W + 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [CNT_W-1:0] depth,
   input  logic [CNT_W-1:0] wmark,
   input  logic             put_req,
   input  logic             ack_req,
   input  logic [IDX_W-1:0] ack_idx,
   input  irq_t             clr,
   output logic             put_ok,
   output logic [IDX_W-1:0] put_idx,
   output logic [IDX_W-1:0] get_idx,
   output logic [CNT_W-1:0] fill,
   output logic             full,
   output irq_t             flags
);
   logic [IDX_W-1:0] put_q, get_q, put_inc, get_jump;
   logic [CNT_W-1:0] fill_q, fill_d, put_p1, ack_p1;
   logic             ack_ok, grow, wm_en;
   irq_t             flags_q, flags_d;

   assign put_p1   = {1'b0, put_q} + 1'b1;
   assign ack_p1   = {1'b0, ack_idx} + 1'b1;
   assign put_inc  = (put_p1 >= depth) ? '0 : put_p1[IDX_W-1:0];
   assign get_jump = (ack_p1 >= depth) ? '0 : ack_p1[IDX_W-1:0];

   assign full   = (fill_q == depth);
   assign put_ok = put_req & ~full;
   assign ack_ok = ack_req & (fill_q != '0);
   assign grow   = put_ok & ~ack_ok;
   assign wm_en  = (wmark != '0) && (wmark <= depth);

   always_comb begin
      case ({put_ok, ack_ok})
         2'b10:   fill_d = fill_q + 1'b1;
         2'b01:   fill_d = fill_q - 1'b1;
         default: fill_d = fill_q;
      endcase
   end

   always_comb begin
      flags_d.wmark = (flags_q.wmark & ~clr.wmark) | (grow & wm_en & (fill_d == wmark));
      flags_d.full  = (flags_q.full  & ~clr.full)  | (grow & (fill_d == depth));
      flags_d.lost  = (flags_q.lost  & ~clr.lost)  | (put_req & ~put_ok);
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         put_q   <= '0;
         get_q   <= '0;
         fill_q  <= '0;
         flags_q <= '0;
      end else begin
         if (put_ok) put_q <= put_inc;
         if (ack_ok) get_q <= get_jump;
         fill_q  <= fill_d;
         flags_q <= flags_d;
      end
   end

   assign put_idx = put_q;
   assign get_idx = get_q;
   assign fill    = fill_q;
   assign flags   = flags_q;
endmodule

// File: rtl/rxq_fifo_mgr.sv
module rxq_fifo_mgr
   import rxq_pkg::*;
#(
   parameter  int NUM_Q     = 2,
   parameter  int IDX_W     = 6,
   parameter  int ADDR_W    = 14,
   parameter  bit MULT_IMPL = 1'b1,
   localparam int CNT_W     = IDX_W + 1,
   localparam int SEL_W     = (NUM_Q > 1) ? $clog2(NUM_Q) : 1
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic [NUM_Q*ADDR_W-1:0] cfg_start,
   input  logic [NUM_Q*CNT_W-1:0]  cfg_depth,
   input  logic [NUM_Q*CNT_W-1:0]  cfg_wmark,
   input  logic [NUM_Q*3-1:0]      cfg_dsize,
   input  logic                    acc_valid,
   input  logic [SEL_W-1:0]        acc_sel,
   output logic                    wr_ok,
   output logic [ADDR_W-1:0]       wr_addr,
   input  logic                    ack_valid,
   input  logic [SEL_W-1:0]        ack_sel,
   input  logic [IDX_W-1:0]        ack_idx,
   input  logic [SEL_W-1:0]        rd_sel,
   output logic [IDX_W-1:0]        rd_get_idx,
   output logic [ADDR_W-1:0]       rd_addr,
   output logic [NUM_Q*IDX_W-1:0]  put_idx,
   output logic [NUM_Q*IDX_W-1:0]  get_idx,
   output logic [NUM_Q*CNT_W-1:0]  fill,
   output logic [NUM_Q-1:0]        full,
   output logic [NUM_Q*3-1:0]      irq_flags,
   input  logic [NUM_Q*3-1:0]      irq_clr
);
   generate
      if (NUM_Q < 1)  begin : g_bad_q   $error("NUM_Q must be at least 1");   end
      if (IDX_W < 1)  begin : g_bad_i   $error("IDX_W must be at least 1");   end
      if (ADDR_W < 2) begin : g_bad_a   $error("ADDR_W must be at least 2");  end
   endgenerate

   logic [ADDR_W-1:0] q_wr_addr [NUM_Q];
   logic [ADDR_W-1:0] q_rd_addr [NUM_Q];
   logic [IDX_W-1:0]  q_get     [NUM_Q];
   logic [NUM_Q-1:0]  q_put_ok;

   genvar q;
   generate
      for (q = 0; q < NUM_Q; q++) begin : g_q
         logic [IDX_W-1:0] pi, gi;
         irq_t             fl;

         rxq_state #(.IDX_W(IDX_W)) u_state (
            .clk     (clk),
            .rst_n   (rst_n),
            .depth   (cfg_depth[q*CNT_W +: CNT_W]),
            .wmark   (cfg_wmark[q*CNT_W +: CNT_W]),
            .put_req (acc_valid && (acc_sel == SEL_W'(q))),
            .ack_req (ack_valid && (ack_sel == SEL_W'(q))),
            .ack_idx (ack_idx),
            .clr     (irq_t'(irq_clr[q*3 +: 3])),
            .put_ok  (q_put_ok[q]),
            .put_idx (pi),
            .get_idx (gi),
            .fill    (fill[q*CNT_W +: CNT_W]),
            .full    (full[q]),
            .flags   (fl)
         );

         rxq_addr_gen #(.ADDR_W(ADDR_W), .IDX_W(IDX_W), .MULT_IMPL(MULT_IMPL)) u_wr_ag (
            .base  (cfg_start[q*ADDR_W +: ADDR_W]),
            .idx   (pi),
            .dsize (dsize_t'(cfg_dsize[q*3 +: 3])),
            .addr  (q_wr_addr[q])
         );

         rxq_addr_gen #(.ADDR_W(ADDR_W), .IDX_W(IDX_W), .MULT_IMPL(MULT_IMPL)) u_rd_ag (
            .base  (cfg_start[q*ADDR_W +: ADDR_W]),
            .idx   (gi),
            .dsize (dsize_t'(cfg_dsize[q*3 +: 3])),
            .addr  (q_rd_addr[q])
         );

         assign put_idx[q*IDX_W +: IDX_W] = pi;
         assign get_idx[q*IDX_W +: IDX_W] = gi;
         assign irq_flags[q*3 +: 3]       = fl;
         assign q_get[q]                  = gi;
      end
   endgenerate

   always_comb begin
      wr_ok      = 1'b0;
      wr_addr    = '0;
      rd_get_idx = '0;
      rd_addr    = '0;
      for (int i = 0; i < NUM_Q; i++) begin
         if (acc_sel == SEL_W'(i)) begin
            wr_ok   = q_put_ok[i];
            wr_addr = q_wr_addr[i];
         end
         if (rd_sel == SEL_W'(i)) begin
            rd_get_idx = q_get[i];
            rd_addr    = q_rd_addr[i];
         end
      end
   end
endmodule

// File: rtl/rxq_fifo_mgr_chk.sv
module rxq_fifo_mgr_chk #(
   parameter  int NUM_Q = 2,
   parameter  int IDX_W = 6,
   localparam int CNT_W = IDX_W + 1,
   localparam int SEL_W = (NUM_Q > 1) ? $clog2(NUM_Q) : 1
) (
   input logic                   clk,
   input logic                   rst_n,
   input logic                   acc_valid,
   input logic [SEL_W-1:0]       acc_sel,
   input logic                   ack_valid,
   input logic [SEL_W-1:0]       ack_sel,
   input logic [NUM_Q*CNT_W-1:0] cfg_depth,
   input logic [NUM_Q*IDX_W-1:0] put_idx,
   input logic [NUM_Q*CNT_W-1:0] fill,
   input logic [NUM_Q-1:0]       full,
   input logic [NUM_Q*3-1:0]     irq_flags,
   input logic [NUM_Q*3-1:0]     irq_clr
);
   genvar q;
   generate
      for (q = 0; q < NUM_Q; q++) begin : g_chk
         logic put_hit, ack_hit;
         assign put_hit = acc_valid && (acc_sel == SEL_W'(q));
         assign ack_hit = ack_valid && (ack_sel == SEL_W'(q));

         a_r4_fill_bound: assert property (@(posedge clk) disable iff (!rst_n)
            fill[q*CNT_W +: CNT_W] <= cfg_depth[q*CNT_W +: CNT_W]);

         a_r4_put_range: assert property (@(posedge clk) disable iff (!rst_n)
            CNT_W'(put_idx[q*IDX_W +: IDX_W]) < cfg_depth[q*CNT_W +: CNT_W]);

         a_r5_full_irq: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(full[q]) |-> irq_flags[q*3+1]);

         a_r6_drop_flag: assert property (@(posedge clk) disable iff (!rst_n)
            (put_hit && full[q]) |=> irq_flags[q*3+2]);

         a_r6_drop_hold: assert property (@(posedge clk) disable iff (!rst_n)
            (put_hit && full[q] && !ack_hit) |=> $stable(put_idx[q*IDX_W +: IDX_W]));

         a_r8_same_cycle: assert property (@(posedge clk) disable iff (!rst_n)
            (put_hit && !full[q] && ack_hit && (fill[q*CNT_W +: CNT_W] != '0))
            |=> $stable(fill[q*CNT_W +: CNT_W]));

         for (genvar b = 0; b < 3; b++) begin : g_bit
            a_r10_sticky: assert property (@(posedge clk) disable iff (!rst_n)
               (irq_flags[q*3+b] && !irq_clr[q*3+b]) |=> irq_flags[q*3+b]);
         end
      end
   endgenerate
endmodule

bind rxq_fifo_mgr rxq_fifo_mgr_chk #(.NUM_Q(NUM_Q), .IDX_W(IDX_W)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .acc_valid (acc_valid),
   .acc_sel   (acc_sel),
   .ack_valid (ack_valid),
   .ack_sel   (ack_sel),
   .cfg_depth (cfg_depth),
   .put_idx   (put_idx),
   .fill      (fill),
   .full      (full),
   .irq_flags (irq_flags),
   .irq_clr   (irq_clr)
);

// File: tb/sim_rxq_fifo_mgr.sv
module sim_rxq_fifo_mgr;
   localparam int NQ = 2;
   localparam int IW = 6;
   localparam int AW = 14;
   localparam int CW = IW + 1;

   logic clk = 1'b0;
   always #10 clk = ~clk;

   logic           rst_n;
   logic [AW-1:0]  c_start [NQ];
   logic [CW-1:0]  c_depth [NQ];
   logic [CW-1:0]  c_wm    [NQ];
   logic [2:0]     c_ds    [NQ];
   logic           acc_valid, ack_valid;
   logic           acc_sel, ack_sel, rd_sel;
   logic [IW-1:0]  ack_idx;
   logic [NQ*3-1:0] irq_clr;

   logic           wr_ok;
   logic [AW-1:0]  wr_addr, rd_addr;
   logic [IW-1:0]  rd_get_idx;
   logic [NQ*IW-1:0] put_idx, get_idx;
   logic [NQ*CW-1:0] fill;
   logic [NQ-1:0]  full;
   logic [NQ*3-1:0] irq_flags;

   rxq_fifo_mgr u0 (
      .clk(clk), .rst_n(rst_n),
      .cfg_start({c_start[1], c_start[0]}),
      .cfg_depth({c_depth[1], c_depth[0]}),
      .cfg_wmark({c_wm[1], c_wm[0]}),
      .cfg_dsize({c_ds[1], c_ds[0]}),
      .acc_valid(acc_valid), .acc_sel(acc_sel), .wr_ok(wr_ok), .wr_addr(wr_addr),
      .ack_valid(ack_valid), .ack_sel(ack_sel), .ack_idx(ack_idx),
      .rd_sel(rd_sel), .rd_get_idx(rd_get_idx), .rd_addr(rd_addr),
      .put_idx(put_idx), .get_idx(get_idx), .fill(fill), .full(full),
      .irq_flags(irq_flags), .irq_clr(irq_clr)
   );

   int checks = 0;
   int failures = 0;
   bit finished = 0;

   int m_put [NQ];
   int m_get [NQ];
   int m_fill[NQ];
   int m_flg [NQ];

   function automatic int words_of(int code);
      case (code)
         0: return 4;  1: return 5;  2: return 6;  3: return 7;
         4: return 8;  5: return 10; 6: return 14; default: return 18;
      endcase
   endfunction

   function automatic int exp_addr(int q, int idx);
      return (int'(c_start[q]) + idx * words_of(int'(c_ds[q]))) % (1 << AW);
   endfunction

   task automatic chk(input string req, input string what, input int act, input int exp);
      checks++;
      if (act != exp) begin
         failures++;
         $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
      end
   endtask

   task automatic model_reset();
      for (int q = 0; q < NQ; q++) begin
         m_put[q] = 0; m_get[q] = 0; m_fill[q] = 0; m_flg[q] = 0;
      end
   endtask

   task automatic check_state();
      for (int q = 0; q < NQ; q++) begin
         chk("R4", $sformatf("put_idx q%0d", q), int'(put_idx[q*IW +: IW]), m_put[q]);
         chk("R7", $sformatf("get_idx q%0d", q), int'(get_idx[q*IW +: IW]), m_get[q]);
         chk("R8", $sformatf("fill q%0d", q), int'(fill[q*CW +: CW]), m_fill[q]);
         chk("R5", $sformatf("full q%0d", q), int'(full[q]), int'(m_fill[q] == int'(c_depth[q])));
         chk("R9/R10", $sformatf("wmark flag q%0d", q), int'(irq_flags[q*3]), m_flg[q] & 1);
         chk("R5/R10", $sformatf("full flag q%0d", q), int'(irq_flags[q*3+1]), (m_flg[q] >> 1) & 1);
         chk("R6/R10", $sformatf("drop flag q%0d", q), int'(irq_flags[q*3+2]), (m_flg[q] >> 2) & 1);
      end
   endtask

   // called at a negedge; applies inputs, checks combinational outputs, advances one edge
   task automatic step(input bit av, input int as, input bit kv, input int ks,
                       input int ki, input int clr, input int rs);
      acc_valid = av; acc_sel = as[0]; ack_valid = kv; ack_sel = ks[0];
      ack_idx = IW'(ki); irq_clr = (NQ*3)'(clr); rd_sel = rs[0];
      #1;
      chk("R3", "wr_addr", int'(wr_addr), exp_addr(as, m_put[as]));
      chk("R3", "rd_addr", int'(rd_addr), exp_addr(rs, m_get[rs]));
      chk("R7", "rd_get_idx", int'(rd_get_idx), m_get[rs]);
      chk("R4/R6", "wr_ok", int'(wr_ok), int'(av && (m_fill[as] != int'(c_depth[as]))));
      for (int q = 0; q < NQ; q++) begin
         int  dep = int'(c_depth[q]);
         int  wm  = int'(c_wm[q]);
         bit  pr  = av && (as == q);
         bit  ar  = kv && (ks == q);
         bit  pok = pr && (m_fill[q] != dep);
         bit  aok = ar && (m_fill[q] != 0);
         int  nf  = m_fill[q] + int'(pok) - int'(aok);
         int  f   = m_flg[q] & ~((clr >> (q*3)) & 7);
         if (pok && !aok && wm != 0 && wm <= dep && nf == wm) f |= 1;
         if (pok && !aok && nf == dep) f |= 2;
         if (pr && !pok) f |= 4;
         if (pok) m_put[q] = (m_put[q] + 1 >= dep) ? 0 : m_put[q] + 1;
         if (aok) m_get[q] = (ki + 1 >= dep) ? 0 : ki + 1;
         m_fill[q] = nf;
         m_flg[q]  = f;
      end
      @(posedge clk);
      @(negedge clk);
      check_state();
   endtask

   task automatic do_reset(input int s0, input int d0, input int w0, input int z0,
                           input int s1, input int d1, input int w1, input int z1);
      rst_n = 1'b0;
      acc_valid = 0; ack_valid = 0; irq_clr = '0;
      c_start[0] = AW'(s0); c_depth[0] = CW'(d0); c_wm[0] = CW'(w0); c_ds[0] = 3'(z0);
      c_start[1] = AW'(s1); c_depth[1] = CW'(d1); c_wm[1] = CW'(w1); c_ds[1] = 3'(z1);
      repeat (2) @(posedge clk);
      @(negedge clk);
      model_reset();
      for (int q = 0; q < NQ; q++) begin
         chk("R11", "reset indices/fill", int'(put_idx[q*IW +: IW]) + int'(get_idx[q*IW +: IW])
             + int'(fill[q*CW +: CW]), 0);
         chk("R11", "reset flags", int'(irq_flags[q*3 +: 3]), 0);
      end
      rst_n = 1'b1;
   endtask

   function automatic int pick_depth();
      int r = $urandom_range(0, 4);
      case (r)
         0: return 1; 1: return 2; 2: return 3; 3: return 64;
         default: return $urandom_range(1, 64);
      endcase
   endfunction

   initial begin
      repeat (200000) @(posedge clk);
      if (!finished) begin
         failures++;
         $display("FAIL watchdog expired actual=hung expected=done");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'd20240611));
      rst_n = 0; acc_valid = 0; ack_valid = 0; acc_sel = 0; ack_sel = 0;
      rd_sel = 0; ack_idx = 0; irq_clr = '0;
      @(negedge clk);

      // R2: each size code, one element in, address steps by the element words
      for (int c = 0; c < 8; c++) begin
         do_reset(0, 4, 0, c, 0, 4, 0, c);
         step(1, 0, 0, 0, 0, 0, 0);
         chk("R2", $sformatf("words for code %0d", c), int'(u0.wr_addr), words_of(c));
      end

      // directed: shallow queue 0, deep queue 1 near the top of the address space
      do_reset(100, 3, 2, 0, 16380, 64, 0, 7);
      step(1, 0, 0, 0, 0, 0, 0);
      step(1, 0, 0, 0, 0, 0, 0);
      chk("R9", "threshold flag at fill 2", int'(irq_flags[0]), 1);
      step(1, 0, 0, 0, 0, 0, 0);
      chk("R5", "full status after third put", int'(full[0]), 1);
      step(1, 0, 0, 0, 0, 0, 1);   // overflow
      chk("R6", "drop flag after overflow", int'(irq_flags[2]), 1);
      chk("R1", "queue 1 untouched", int'(fill[CW +: CW]) + int'(irq_flags[5:3]), 0);
      step(0, 0, 1, 1, 5, 0, 1);   // ack to empty queue 1 ignored
      chk("R7", "empty ack keeps get", int'(get_idx[IW +: IW]), 0);
      step(0, 0, 1, 0, 0, 0, 0);   // consume index 0
      step(1, 0, 1, 0, 1, 0, 0);   // simultaneous put and ack
      chk("R8", "fill held on simultaneous ops", int'(fill[0 +: CW]), 2);
      step(0, 0, 0, 0, 0, 7, 0);   // clear all of queue 0
      chk("R10", "flags cleared", int'(irq_flags[2:0]), 0);
      step(1, 0, 0, 0, 0, 2, 0);   // set and clear full together
      chk("R10", "set wins over clear", int'(irq_flags[1]), 1);
      for (int i = 0; i < 70; i++) step(1, 1, 0, 0, 0, 0, 1);
      chk("R9", "threshold 0 never fires", int'(irq_flags[3]), 0);
      chk("R3", "wrapped read address", int'(rd_addr), exp_addr(1, 0));

      // random phases
      for (int cfg = 0; cfg < 6; cfg++) begin
         int d0 = pick_depth();
         int d1 = pick_depth();
         do_reset($urandom_range(0, 16383), d0, $urandom_range(0, d0 + 4), $urandom_range(0, 7),
                  $urandom_range(0, 16383), d1, $urandom_range(0, d1 + 4), $urandom_range(0, 7));
         for (int n = 0; n < 2500; n++) begin
            bit heavy_put = ((n / 200) % 2) == 0;
            bit av = $urandom_range(0, 99) < (heavy_put ? 85 : 30);
            int as = $urandom_range(0, 1);
            bit kv = $urandom_range(0, 99) < (heavy_put ? 20 : 75);
            int ks = $urandom_range(0, 1);
            int ki = ($urandom_range(0, 9) == 0) ? $urandom_range(0, 63) : m_get[ks];
            int cl = ($urandom_range(0, 15) == 0) ? $urandom_range(0, 63) : 0;
            step(av, as, kv, ks, ki, cl, $urandom_range(0, 1));
         end
      end

      finished = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule